// File: doc/BRIEF.md
# Predicated Dataflow Issue Window

This block is the instruction window of a single block engine. A whole block of up to `NENT` instructions, already in single-assignment form, is written into the window one entry at a time. Each entry carries a class code, a destination tag, two source operands and an optional guard predicate tag. Each source operand is either present at load time or identified only by a tag. There is no register file inside the engine. Producers broadcast `(tag, value)` pairs on `NBUS` result buses. Every waiting entry compares its source and guard tags against every bus and keeps a matching value in its own operand storage.

While the window runs, a picker sends ready entries to the functional units, up to `ISSUE_W` per cycle and the oldest (lowest index) first. Only entries inside the current sub-window of `SUBW` consecutive entries are considered. An entry whose last missing operand appears on a bus in cycle t issues in that same cycle t, and the bus value is forwarded to the issue port. This lets a dependent instruction issue right behind its producer.

A guarded entry may issue while its predicate is still unknown or known true. A predicate broadcast as false stops it from issuing and retires it as nullified. Every issue slot reports the execution latency of its class. Divides are not pipelined, so a second divide waits until the divider is free.

The controller has four states:
- `S_IDLE`: after reset. `blk_start` moves it to `S_LOAD`.
- `S_LOAD`: entries are written. `blk_go` moves it to `S_RUN` with sub-window 0.
- `S_RUN`: issue takes place. A finished sub-window advances to the next one. Finishing the last sub-window moves it to `S_DONE`.
- `S_DONE`: `blk_start` clears the window and returns to `S_LOAD`.

Top module: `pdw_issue_window`

## Requirements
- R1: After reset the window is in `S_IDLE`: `iss_valid` is 0, `busy` is 0 and `blk_done` is 0.
- R2: An entry issues only when both source operands are available, either marked present at load or received from a result bus. An entry still missing an operand does not issue.
- R3: When a result bus carries a tag equal to a missing source tag of an entry, the entry stores the bus value. That value later appears on the matching `iss_a`/`iss_b` field of its issue slot.
- R4: An entry whose last missing operand arrives on either result bus in cycle t issues in cycle t, and the bus value appears on the issue port in that cycle.
- R5: A guarded entry may issue while its guard is unknown or true. A guard broadcast with bit 0 of the value equal to 0 (false) blocks issue, including in the cycle it appears on a bus. That entry never issues and counts as finished. Bit 0 equal to 1 means true.
- R6: Only entries whose index divided by `SUBW` equals the current sub-window number may issue.
- R7: The sub-window starts at 0. It moves to the next group on the clock edge that ends the first cycle in which every entry of the current group has issued, has been nullified, or was never loaded. That cycle issues nothing from the group.
- R8: Each cycle, eligible entries go to the issue slots in increasing index order. Slot 0 gets the oldest, and at most `ISSUE_W` entries issue per cycle.
- R9: `iss_lat` reports the latency from the class code: 0 integer→1, 1 load→3, 2 multiply→8, 3 floating point→4, 4 single divide→18, 5 double divide→31.
- R10: At most one divide issues per cycle. After a divide with latency L issues in cycle t, no divide issues before cycle t+L, and a ready divide issues in cycle t+L.
- R11: `blk_done` rises in the cycle after the last sub-window has finished. It stays high until the next accepted `blk_start`.
- R12: `blk_start` is accepted in `S_IDLE` or `S_DONE` and clears every entry. `ld_we` writes entry `ld_idx` only in `S_LOAD`. Nothing issues before `blk_go`, and `blk_go` starts issue in the next cycle at sub-window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Clear the window and begin loading a new block |
| ld_we | input | 1 | Write one entry this cycle |
| ld_idx | input | IDXW | Entry index to write |
| ld_cls | input | 3 | Class code of the instruction |
| ld_dst | input | TAG_W | Destination tag |
| ld_a_tag | input | TAG_W | Source A tag |
| ld_a_have | input | 1 | Source A value already present |
| ld_a_val | input | DATA_W | Source A value when present |
| ld_b_tag | input | TAG_W | Source B tag |
| ld_b_have | input | 1 | Source B value already present |
| ld_b_val | input | DATA_W | Source B value when present |
| ld_g_use | input | 1 | Entry is guarded by a predicate |
| ld_g_tag | input | TAG_W | Guard predicate tag |
| blk_go | input | 1 | Loading finished, start issue |
| rb_valid | input | NBUS | Result bus valid, one bit per bus |
| rb_tag | input | NBUS*TAG_W | Result bus tags, bus k at bits k*TAG_W |
| rb_val | input | NBUS*DATA_W | Result bus values, bus k at bits k*DATA_W |
| iss_valid | output | ISSUE_W | Issue slot valid |
| iss_idx | output | ISSUE_W*IDXW | Entry index per slot |
| iss_cls | output | ISSUE_W*3 | Class code per slot |
| iss_dst | output | ISSUE_W*TAG_W | Destination tag per slot |
| iss_a | output | ISSUE_W*DATA_W | Source A value per slot |
| iss_b | output | ISSUE_W*DATA_W | Source B value per slot |
| iss_lat | output | ISSUE_W*5 | Latency of the issued class per slot |
| busy | output | 1 | Window is in `S_RUN` |
| blk_done | output | 1 | Block finished |

## Verification
The hardest situations to reach from the ports are those where two events coincide in one cycle. One is a guard that turns false in exactly the cycle its entry would otherwise win a slot. Another is a second divide that has waited out the divider's full busy window. The bench loads a block in which the guarded entry is ready at `blk_go`. It broadcasts the false predicate in the first run cycle, so the younger unguarded entry must take the freed slot. For the divider, two divides sit side by side with a multiply and a load. Every cycle of the 18-cycle busy window is checked for silence, and the exact cycle the second divide is released is checked too. Bypass is tested on each bus separately, with one operand captured earlier and the other forwarded in the issue cycle.

// File: rtl/pdw_pkg.sv
`timescale 1ns/1ps
package pdw_pkg;
    parameter int TAG_W  = 6;
    parameter int DATA_W = 16;
    localparam int CLS_W = 3;
    localparam int LAT_W = 5;

    typedef enum logic [CLS_W-1:0] {
        CL_INT  = 3'd0,
        CL_LOAD = 3'd1,
        CL_MUL  = 3'd2,
        CL_FP   = 3'd3,
        CL_DIVS = 3'd4,
        CL_DIVD = 3'd5
    } cls_e;

    typedef enum logic [1:0] {G_OPEN, G_TRUE, G_FALSE} gst_e;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_DONE} st_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              have;
        logic [DATA_W-1:0] val;
    } src_t;

    typedef struct packed {
        cls_e             cls;
        logic [TAG_W-1:0] dst;
        src_t             a;
        src_t             b;
        logic             g_use;
        logic [TAG_W-1:0] g_tag;
    } slot_t;

    function automatic logic [LAT_W-1:0] class_lat(input cls_e c);
        logic [LAT_W-1:0] l;
        case (c)
            CL_INT:  l = LAT_W'(1);
            CL_LOAD: l = LAT_W'(3);
            CL_MUL:  l = LAT_W'(8);
            CL_FP:   l = LAT_W'(4);
            CL_DIVS: l = LAT_W'(18);
            CL_DIVD: l = LAT_W'(31);
            default: l = LAT_W'(1);
        endcase
        return l;
    endfunction

    function automatic logic is_div(input cls_e c);
        return (c == CL_DIVS) || (c == CL_DIVD);
    endfunction
endpackage

// File: rtl/pdw_slot.sv
`timescale 1ns/1ps
module pdw_slot
    import pdw_pkg::*;
#(
    parameter int NBUS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   ld,
    input  slot_t                  ld_info,
    input  logic                   run,
    input  logic [NBUS-1:0]        bv,
    input  logic [NBUS*TAG_W-1:0]  btag,
    input  logic [NBUS*DATA_W-1:0] bval,
    input  logic                   fire,
    output logic                   live,
    output logic                   ready,
    output logic                   gkill,
    output logic                   finished,
    output logic [DATA_W-1:0]      opa,
    output logic [DATA_W-1:0]      opb,
    output cls_e                   cls,
    output logic [TAG_W-1:0]       dst
);
    logic              valid_q, issued_q, null_q;
    slot_t             info_q;
    gst_e              gst_q;
    logic              a_hit, b_hit, g_hit, g_bit;
    logic [DATA_W-1:0] a_bus, b_bus;

    // tag match against every bus; the lowest-numbered bus wins
    always_comb begin
        a_hit = 1'b0;
        b_hit = 1'b0;
        g_hit = 1'b0;
        g_bit = 1'b0;
        a_bus = '0;
        b_bus = '0;
        for (int k = NBUS - 1; k >= 0; k--) begin
            if (run && bv[k]) begin
                if (btag[k*TAG_W +: TAG_W] == info_q.a.tag) begin
                    a_hit = 1'b1;
                    a_bus = bval[k*DATA_W +: DATA_W];
                end
                if (btag[k*TAG_W +: TAG_W] == info_q.b.tag) begin
                    b_hit = 1'b1;
                    b_bus = bval[k*DATA_W +: DATA_W];
                end
                if (btag[k*TAG_W +: TAG_W] == info_q.g_tag) begin
                    g_hit = 1'b1;
                    g_bit = bval[k*DATA_W];
                end
            end
        end
    end

    assign live     = valid_q && !issued_q && !null_q;
    assign finished = !live;
    assign ready    = (info_q.a.have || a_hit) && (info_q.b.have || b_hit);
    assign gkill    = info_q.g_use &&
                      (gst_q == G_FALSE || (gst_q == G_OPEN && g_hit && !g_bit));
    assign opa      = info_q.a.have ? info_q.a.val : a_bus;
    assign opb      = info_q.b.have ? info_q.b.val : b_bus;
    assign cls      = info_q.cls;
    assign dst      = info_q.dst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            issued_q <= 1'b0;
            null_q   <= 1'b0;
            info_q   <= '0;
            gst_q    <= G_OPEN;
        end else if (clr) begin
            valid_q  <= 1'b0;
            issued_q <= 1'b0;
            null_q   <= 1'b0;
        end else if (ld) begin
            valid_q  <= 1'b1;
            issued_q <= 1'b0;
            null_q   <= 1'b0;
            info_q   <= ld_info;
            gst_q    <= G_OPEN;
        end else begin
            if (fire)
                issued_q <= 1'b1;
            if (live && gkill)
                null_q <= 1'b1;
            if (!info_q.a.have && a_hit) begin
                info_q.a.have <= 1'b1;
                info_q.a.val  <= a_bus;
            end
            if (!info_q.b.have && b_hit) begin
                info_q.b.have <= 1'b1;
                info_q.b.val  <= b_bus;
            end
            if (info_q.g_use && gst_q == G_OPEN && g_hit)
                gst_q <= g_bit ? G_TRUE : G_FALSE;
        end
    end

    assert_fire_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (live && ready));
    assert_fire_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !gkill);
    assert_null_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (null_q && !clr && !ld) |=> (null_q && !issued_q));
endmodule

// File: rtl/pdw_pick.sv
`timescale 1ns/1ps
module pdw_pick #(
    parameter int NENT    = 8,
    parameter int SUBW    = 4,
    parameter int ISSUE_W = 2,
    parameter int IDXW    = 3,
    parameter int GRPW    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NENT-1:0]         cand,
    input  logic [NENT-1:0]         divmask,
    input  logic                    div_free,
    input  logic [GRPW-1:0]         grp,
    output logic [NENT-1:0]         grant,
    output logic [ISSUE_W-1:0]      sv,
    output logic [ISSUE_W*IDXW-1:0] sidx
);
    // oldest-first linear scan restricted to the current sub-window
    always_comb begin
        int  n;
        logic dtaken;
        n      = 0;
        dtaken = 1'b0;
        grant  = '0;
        sv     = '0;
        sidx   = '0;
        for (int i = 0; i < NENT; i++) begin
            if (cand[i] && (i / SUBW) == int'(grp) && n < ISSUE_W &&
                (!divmask[i] || (div_free && !dtaken))) begin
                grant[i]               = 1'b1;
                sv[n]                  = 1'b1;
                sidx[n*IDXW +: IDXW]   = IDXW'(i);
                if (divmask[i])
                    dtaken = 1'b1;
                n++;
            end
        end
    end

    assert_issue_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= ISSUE_W);
    assert_one_divide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant & divmask) <= 1);
    assert_div_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !div_free |-> ((grant & divmask) == '0));
endmodule

// File: rtl/pdw_ctrl.sv
`timescale 1ns/1ps
module pdw_ctrl
    import pdw_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int GRPW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_start,
    input  logic             blk_go,
    input  logic             grp_done,
    input  logic             div_fire,
    input  logic [LAT_W-1:0] div_lat,
    output logic             accept,
    output logic             loading,
    output logic             run,
    output logic             done,
    output logic [GRPW-1:0]  grp,
    output logic             div_free
);
    st_e              st_q, st_d;
    logic [GRPW-1:0]  grp_q, grp_d;
    logic [LAT_W-1:0] dcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            grp_q <= '0;
        end else begin
            st_q  <= st_d;
            grp_q <= grp_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        grp_d = grp_q;
        unique case (st_q)
            S_IDLE: if (blk_start) st_d = S_LOAD;
            S_LOAD: if (blk_go) begin
                st_d  = S_RUN;
                grp_d = '0;
            end
            S_RUN: if (grp_done) begin
                if (grp_q == GRPW'(NGRP - 1))
                    st_d = S_DONE;
                else
                    grp_d = grp_q + GRPW'(1);
            end
            S_DONE: if (blk_start) st_d = S_LOAD;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept  = blk_start && (st_q == S_IDLE || st_q == S_DONE);
        loading = (st_q == S_LOAD);
        run     = (st_q == S_RUN);
        done    = (st_q == S_DONE);
        grp     = grp_q;
    end

    // non-pipelined divider occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dcnt_q <= '0;
        else if (div_fire)
            dcnt_q <= div_lat - LAT_W'(1);
        else if (dcnt_q != '0)
            dcnt_q <= dcnt_q - LAT_W'(1);
    end
    assign div_free = (dcnt_q == '0);

    assert_div_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_fire |-> div_free);
    assert_grp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN && !grp_done) |=> $stable(grp_q));
    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DONE && !blk_start) |=> (st_q == S_DONE));
    assert_go_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LOAD && blk_go) |=> (st_q == S_RUN && grp_q == '0));
endmodule

// File: rtl/pdw_issue_window.sv
`timescale 1ns/1ps
module pdw_issue_window
    import pdw_pkg::*;
#(
    parameter int NENT    = 8,
    parameter int SUBW    = 4,
    parameter int ISSUE_W = 2,
    parameter int NBUS    = 2,
    localparam int IDXW   = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        blk_start,
    input  logic                        ld_we,
    input  logic [IDXW-1:0]             ld_idx,
    input  logic [CLS_W-1:0]            ld_cls,
    input  logic [TAG_W-1:0]            ld_dst,
    input  logic [TAG_W-1:0]            ld_a_tag,
    input  logic                        ld_a_have,
    input  logic [DATA_W-1:0]           ld_a_val,
    input  logic [TAG_W-1:0]            ld_b_tag,
    input  logic                        ld_b_have,
    input  logic [DATA_W-1:0]           ld_b_val,
    input  logic                        ld_g_use,
    input  logic [TAG_W-1:0]            ld_g_tag,
    input  logic                        blk_go,
    input  logic [NBUS-1:0]             rb_valid,
    input  logic [NBUS*TAG_W-1:0]       rb_tag,
    input  logic [NBUS*DATA_W-1:0]      rb_val,
    output logic [ISSUE_W-1:0]          iss_valid,
    output logic [ISSUE_W*IDXW-1:0]     iss_idx,
    output logic [ISSUE_W*CLS_W-1:0]    iss_cls,
    output logic [ISSUE_W*TAG_W-1:0]    iss_dst,
    output logic [ISSUE_W*DATA_W-1:0]   iss_a,
    output logic [ISSUE_W*DATA_W-1:0]   iss_b,
    output logic [ISSUE_W*LAT_W-1:0]    iss_lat,
    output logic                        busy,
    output logic                        blk_done
);
    localparam int NGRP = NENT / SUBW;
    localparam int GRPW = (NGRP > 1) ? $clog2(NGRP) : 1;

    slot_t             ld_info;
    logic              accept, loading, run, done, div_free, div_fire, grp_done;
    logic [GRPW-1:0]   grp;
    logic [LAT_W-1:0]  div_lat;
    logic [NENT-1:0]   live, ready, gkill, finished, cand, divmask, grant;
    logic [NGRP-1:0]   gdone;
    logic [ISSUE_W-1:0]      sv;
    logic [ISSUE_W*IDXW-1:0] sidx;
    logic [DATA_W-1:0] opa_a [NENT];
    logic [DATA_W-1:0] opb_a [NENT];
    cls_e              cls_a [NENT];
    logic [TAG_W-1:0]  dst_a [NENT];

    always_comb begin
        ld_info.cls    = cls_e'(ld_cls);
        ld_info.dst    = ld_dst;
        ld_info.a.tag  = ld_a_tag;
        ld_info.a.have = ld_a_have;
        ld_info.a.val  = ld_a_val;
        ld_info.b.tag  = ld_b_tag;
        ld_info.b.have = ld_b_have;
        ld_info.b.val  = ld_b_val;
        ld_info.g_use  = ld_g_use;
        ld_info.g_tag  = ld_g_tag;
    end

    for (genvar e = 0; e < NENT; e++) begin : g_slot
        pdw_slot #(.NBUS(NBUS)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (accept),
            .ld       (loading && ld_we && ld_idx == IDXW'(e)),
            .ld_info  (ld_info),
            .run      (run),
            .bv       (rb_valid),
            .btag     (rb_tag),
            .bval     (rb_val),
            .fire     (grant[e]),
            .live     (live[e]),
            .ready    (ready[e]),
            .gkill    (gkill[e]),
            .finished (finished[e]),
            .opa      (opa_a[e]),
            .opb      (opb_a[e]),
            .cls      (cls_a[e]),
            .dst      (dst_a[e])
        );
        assign cand[e]    = run && live[e] && ready[e] && !gkill[e];
        assign divmask[e] = is_div(cls_a[e]);
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        assign gdone[k] = &finished[k*SUBW +: SUBW];
    end
    assign grp_done = gdone[grp];

    always_comb begin
        div_fire = 1'b0;
        div_lat  = '0;
        for (int i = 0; i < NENT; i++) begin
            if (grant[i] && divmask[i]) begin
                div_fire = 1'b1;
                div_lat  = class_lat(cls_a[i]);
            end
        end
    end

    pdw_pick #(
        .NENT(NENT), .SUBW(SUBW), .ISSUE_W(ISSUE_W), .IDXW(IDXW), .GRPW(GRPW)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .divmask  (divmask),
        .div_free (div_free),
        .grp      (grp),
        .grant    (grant),
        .sv       (sv),
        .sidx     (sidx)
    );

    pdw_ctrl #(.NGRP(NGRP), .GRPW(GRPW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .blk_go    (blk_go),
        .grp_done  (grp_done),
        .div_fire  (div_fire),
        .div_lat   (div_lat),
        .accept    (accept),
        .loading   (loading),
        .run       (run),
        .done      (done),
        .grp       (grp),
        .div_free  (div_free)
    );

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_iss
        logic [IDXW-1:0] pi;
        assign pi = sidx[s*IDXW +: IDXW];
        assign iss_valid[s]                     = sv[s];
        assign iss_idx[s*IDXW +: IDXW]          = pi;
        assign iss_cls[s*CLS_W +: CLS_W]        = cls_a[pi];
        assign iss_dst[s*TAG_W +: TAG_W]        = dst_a[pi];
        assign iss_a[s*DATA_W +: DATA_W]        = opa_a[pi];
        assign iss_b[s*DATA_W +: DATA_W]        = opb_a[pi];
        assign iss_lat[s*LAT_W +: LAT_W]        = class_lat(cls_a[pi]);

        assert_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sv[s] |-> ((int'(pi) / SUBW) == int'(grp)));
    end

    assign busy     = run;
    assign blk_done = done;
endmodule

// File: tb/pdw_issue_window_bench.sv
`timescale 1ns/1ps
module pdw_issue_window_bench;
    localparam int TW = 6;
    localparam int DW = 16;
    localparam int IW = 3;
    localparam int LW = 5;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           blk_start, ld_we, ld_a_have, ld_b_have, ld_g_use, blk_go;
    logic [IW-1:0]  ld_idx;
    logic [2:0]     ld_cls;
    logic [TW-1:0]  ld_dst, ld_a_tag, ld_b_tag, ld_g_tag;
    logic [DW-1:0]  ld_a_val, ld_b_val;
    logic [1:0]     rb_valid;
    logic [2*TW-1:0] rb_tag;
    logic [2*DW-1:0] rb_val;
    logic [1:0]     iss_valid;
    logic [2*IW-1:0] iss_idx;
    logic [5:0]     iss_cls;
    logic [2*TW-1:0] iss_dst;
    logic [2*DW-1:0] iss_a, iss_b;
    logic [2*LW-1:0] iss_lat;
    logic           busy, blk_done;

    int total = 0;
    int bad   = 0;
    bit finished_run = 1'b0;

    always #4 clk = ~clk;

    pdw_issue_window u_pdw_issue_window (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .ld_we(ld_we),
        .ld_idx(ld_idx), .ld_cls(ld_cls), .ld_dst(ld_dst),
        .ld_a_tag(ld_a_tag), .ld_a_have(ld_a_have), .ld_a_val(ld_a_val),
        .ld_b_tag(ld_b_tag), .ld_b_have(ld_b_have), .ld_b_val(ld_b_val),
        .ld_g_use(ld_g_use), .ld_g_tag(ld_g_tag), .blk_go(blk_go),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_val(rb_val),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_cls(iss_cls),
        .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b), .iss_lat(iss_lat),
        .busy(busy), .blk_done(blk_done)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        ld_we     = 1'b0;
        blk_start = 1'b0;
        blk_go    = 1'b0;
        rb_valid  = '0;
    endtask

    task automatic settle();
        #3;
    endtask

    task automatic bus(input int b, input int tag, input int val);
        rb_valid[b]         = 1'b1;
        rb_tag[b*TW +: TW]  = TW'(tag);
        rb_val[b*DW +: DW]  = DW'(val);
    endtask

    task automatic ld(input int idx, input int cls, input int dst,
                      input int at, input bit ah, input int av,
                      input int bt, input bit bh, input int bvv,
                      input bit gu, input int gt);
        ld_we = 1'b1; ld_idx = IW'(idx); ld_cls = 3'(cls); ld_dst = TW'(dst);
        ld_a_tag = TW'(at); ld_a_have = ah; ld_a_val = DW'(av);
        ld_b_tag = TW'(bt); ld_b_have = bh; ld_b_val = DW'(bvv);
        ld_g_use = gu; ld_g_tag = TW'(gt);
        cyc();
    endtask

    task automatic start_block();
        blk_start = 1'b1;
        cyc();
    endtask

    task automatic go();
        blk_go = 1'b1;
        cyc();
    endtask

    function automatic int sidx(input int s); return int'(iss_idx[s*IW +: IW]); endfunction
    function automatic int sa(input int s);   return int'(iss_a[s*DW +: DW]); endfunction
    function automatic int sb(input int s);   return int'(iss_b[s*DW +: DW]); endfunction
    function automatic int sl(input int s);   return int'(iss_lat[s*LW +: LW]); endfunction

    task automatic t_reset();
        settle();
        chk("R1", "iss_valid after reset", iss_valid, 0);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "blk_done after reset", blk_done, 0);
    endtask

    task automatic t_order_window();
        start_block();
        ld(0, 0, 1, 0, 1, 100, 0, 1, 200, 0, 0);
        settle();
        chk("R12", "no issue while loading", iss_valid, 0);
        for (int i = 1; i < 6; i++) ld(i, 0, 1 + i, 0, 1, 100 + i, 0, 1, 200 + i, 0, 0);
        go();
        settle();
        chk("R8", "c0 valid", iss_valid, 3);
        chk("R8", "c0 slot0 oldest", sidx(0), 0);
        chk("R8", "c0 slot1", sidx(1), 1);
        chk("R2", "c0 slot0 a", sa(0), 100);
        chk("R2", "c0 slot1 b", sb(1), 201);
        chk("R9", "integer latency", sl(0), 1);
        cyc(); settle();
        chk("R8", "c1 slot0", sidx(0), 2);
        chk("R8", "c1 slot1", sidx(1), 3);
        cyc(); settle();
        chk("R6", "entries 4,5 held outside window", iss_valid, 0);
        cyc(); settle();
        chk("R7", "group 1 issues after advance", iss_valid, 3);
        chk("R7", "c3 slot0", sidx(0), 4);
        chk("R7", "c3 slot1", sidx(1), 5);
        chk("R11", "not done while running", blk_done, 0);
        cyc(); settle();
        chk("R11", "not done in last group bubble", blk_done, 0);
        cyc(); settle();
        chk("R11", "done after last group", blk_done, 1);
        cyc(); settle();
        chk("R11", "done holds", blk_done, 1);
    endtask

    task automatic t_capture_bypass();
        start_block();
        settle();
        chk("R12", "blk_start clears done", blk_done, 0);
        ld(0, 0, 12, 10, 0, 0, 0, 1, 7, 0, 0);
        ld(1, 0, 13, 11, 0, 0, 10, 0, 0, 0, 0);
        go();
        settle();
        chk("R2", "missing operands block issue", iss_valid, 0);
        cyc(); bus(0, 10, 'h1234); settle();
        chk("R4", "bypass bus0 issues same cycle", iss_valid, 1);
        chk("R4", "bypass bus0 index", sidx(0), 0);
        chk("R4", "bypass bus0 value", sa(0), 'h1234);
        chk("R2", "present operand b", sb(0), 7);
        cyc(); bus(1, 11, 'h55AA); settle();
        chk("R4", "bypass bus1 issues", iss_valid, 1);
        chk("R4", "bypass bus1 index", sidx(0), 1);
        chk("R4", "bypass bus1 value", sa(0), 'h55AA);
        chk("R3", "captured operand b", sb(0), 'h1234);
        cyc(); settle();
        chk("R7", "bubble after group finished", iss_valid, 0);
        cyc(); cyc(); settle();
        chk("R11", "done with unloaded group", blk_done, 1);
    endtask

    task automatic t_guard();
        start_block();
        ld(0, 0, 40, 0, 1, 1, 0, 1, 2, 1, 20);
        ld(1, 0, 41, 0, 1, 3, 0, 1, 4, 1, 21);
        ld(2, 0, 42, 31, 0, 0, 0, 1, 5, 1, 22);
        ld(3, 0, 43, 0, 1, 6, 0, 1, 8, 0, 0);
        go();
        bus(0, 21, 0);
        settle();
        chk("R5", "c0 two issues", iss_valid, 3);
        chk("R5", "unknown guard issues", sidx(0), 0);
        chk("R5", "false guard skipped same cycle", sidx(1), 3);
        cyc(); bus(0, 22, 1); bus(1, 31, 'h0777); settle();
        chk("R5", "true guard single issue", iss_valid, 1);
        chk("R5", "true guard entry", sidx(0), 2);
        chk("R3", "bypassed operand", sa(0), 'h0777);
        cyc(); settle();
        chk("R5", "nullified entry never issues", iss_valid, 0);
        cyc(); settle();
        chk("R5", "no late issue", iss_valid, 0);
        cyc(); settle();
        chk("R5", "nullified entry counts finished", blk_done, 1);
    endtask

    task automatic t_divide();
        start_block();
        ld(0, 4, 50, 0, 1, 1, 0, 1, 1, 0, 0);
        ld(1, 5, 51, 0, 1, 1, 0, 1, 1, 0, 0);
        ld(2, 2, 52, 0, 1, 1, 0, 1, 1, 0, 0);
        ld(3, 1, 53, 0, 1, 1, 0, 1, 1, 0, 0);
        ld(4, 3, 54, 0, 1, 1, 0, 1, 1, 0, 0);
        ld(5, 0, 55, 0, 1, 1, 0, 1, 1, 0, 0);
        go();
        settle();
        chk("R10", "c0 valid", iss_valid, 3);
        chk("R10", "first divide", sidx(0), 0);
        chk("R10", "second divide held, multiply next", sidx(1), 2);
        chk("R9", "single divide latency", sl(0), 18);
        chk("R9", "multiply latency", sl(1), 8);
        cyc(); settle();
        chk("R10", "c1 only load", iss_valid, 1);
        chk("R10", "c1 load index", sidx(0), 3);
        chk("R9", "load latency", sl(0), 3);
        for (int k = 2; k <= 17; k++) begin
            cyc(); settle();
            chk("R10", "divider busy", iss_valid, 0);
        end
        cyc(); settle();
        chk("R10", "divide released at t+L", iss_valid, 1);
        chk("R10", "released divide index", sidx(0), 1);
        chk("R9", "double divide latency", sl(0), 31);
        cyc(); settle();
        chk("R7", "bubble", iss_valid, 0);
        cyc(); settle();
        chk("R9", "group 1 valid", iss_valid, 3);
        chk("R9", "fp latency", sl(0), 4);
        chk("R9", "int latency", sl(1), 1);
        cyc(); cyc(); settle();
        chk("R11", "divide block done", blk_done, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        blk_start = 0; ld_we = 0; blk_go = 0; ld_idx = '0; ld_cls = '0; ld_dst = '0;
        ld_a_tag = '0; ld_a_have = 0; ld_a_val = '0; ld_b_tag = '0; ld_b_have = 0;
        ld_b_val = '0; ld_g_use = 0; ld_g_tag = '0;
        rb_valid = '0; rb_tag = '0; rb_val = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        cyc();
        t_order_window();
        t_capture_bypass();
        t_guard();
        t_divide();
        finished_run = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished_run) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule